// File: doc/BRIEF.md
# Gated Frequency Meter with Decade Timebase

The block measures how often an unknown signal rises. It counts those rising edges during a sampling window whose length is known exactly. A reference tick enters as a one-cycle enable in the system clock domain, nominally at 100 kHz. It drives a chain of decade dividers. The range select picks one divider output, from the first decade (10 kHz) down to the fifth (1 Hz), and that output sets the window length.

The chosen tap drives a toggle stage, which halves it into a sampling square wave. A second toggle stage flips on each falling transition of the sampling wave and forms the gate flag. When the gate flag rises, a one-cycle clear empties a BCD accumulator. The accumulator then counts synchronized input edges for one high half of the sampling wave, while the gate flag and the sampling wave are both high. When the window shuts, the held result is replaced and a done pulse marks the update. With the 1 Hz tap the window is one second long, so the result reads directly in hertz. Shorter windows give a reading that is uncertain by one count, depending on where the window falls against the input.

The result is a plain held register with a strobe. It has no back-pressure: a consumer must capture the result on the done pulse or read it any time before the next one.

Top module: `freq_gate_meter`

## Requirements
- R1: While reset is asserted, and until the first measurement completes, result is 0, overflow is 0 and done is 0.
- R2: For range select value s (0 to 4), the counting window lasts exactly 10^(s+1) reference ticks. Select values above 4 behave as 4.
- R3: One measurement takes four tap periods: 4*10^(s+1) reference ticks. With a steady tick rate, successive done pulses are spaced exactly that many ticks apart.
- R4: Only rising edges of sig_in are counted, after a two-flop synchronizer. A level held steady adds nothing.
- R5: result is packed BCD with 4 bits per digit. The least significant decimal digit sits in bits [3:0], and no digit ever exceeds 9.
- R6: done is a one-cycle pulse issued two cycles after the window closes. result and overflow change only in the cycle done is high.
- R7: The accumulator saturates at all nines. An edge arriving at saturation sets overflow, which is reported with that result.
- R8: The accumulator is cleared when the gate flag rises. Each result covers only its own window, and overflow from an earlier window does not carry over.
- R9: A change of the effective range select restarts the timebase, both toggle stages and the accumulator. No done is issued for a window begun under the old range.
- R10: The timebase advances only on cycles with ref_tick high. With the tick held low, no window closes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | One-cycle reference enable, nominally 100 kHz |
| sig_in | input | 1 | Unknown signal, asynchronous to clk |
| range_sel | input | 3 | Timebase tap index; 0 is the shortest window |
| result | output | 4*DIGITS (20) | Held BCD count of the last completed window |
| overflow | output | 1 | The last completed window saturated |
| done | output | 1 | One-cycle strobe marking a new result |

## Verification
An input edge reaches the accumulator three clock edges after sig_in changes: two synchronizer stages, then the increment. It counts only if the window is open at that third edge. The result and done appear two edges after the tick that closes the window. A range change takes effect at the first edge that sees it, and done is suppressed from the edge after that. The bench model carries each of these latencies as explicit per-cycle state. It compares result, overflow and done against the design on every falling edge. Spacing, clamp-free range and saturation checks count cycles from observed done pulses rather than from fixed delays.

// File: rtl/fgm_pkg.sv
package fgm_pkg;
  localparam int NIB = 4;
  typedef logic [NIB-1:0] bcd_digit_t;
  localparam bcd_digit_t BCD_TOP = 4'd9;
endpackage

// File: rtl/fgm_timebase.sv
module fgm_timebase #(
  parameter int STAGES = 5,
  parameter int RADIX  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              tick,
  output logic [STAGES-1:0] carry
);
  localparam int DW = (RADIX > 2) ? $clog2(RADIX) : 1;
  localparam logic [DW-1:0] LAST = DW'(RADIX - 1);

  logic [STAGES:0] run;
  assign run[0] = tick;

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    logic [DW-1:0] dig;
    assign run[k+1] = run[k] & (dig == LAST);
    assign carry[k] = run[k+1];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       dig <= '0;
      else if (restart) dig <= '0;
      else if (run[k])  dig <= (dig == LAST) ? '0 : dig + 1'b1;
    end
  end
endmodule

// File: rtl/fgm_edge_sync.sv
module fgm_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic meta, stab, prev;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= 1'b0;
      stab <= 1'b0;
      prev <= 1'b0;
    end else begin
      meta <= async_in;
      stab <= meta;
      prev <= stab;
    end
  end
  assign rise = stab & ~prev;
endmodule

// File: rtl/fgm_gate_ctrl.sv
module fgm_gate_ctrl #(
  parameter int STAGES = 5,
  parameter int SW     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic [STAGES-1:0] carry,
  input  logic [SW-1:0]     sel,
  output logic              win_open,
  output logic              clr_pulse,
  output logic              win_close
);
  logic tap_fall;
  logic samp_q, gate_q;

  assign tap_fall = carry[sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q <= 1'b0;
      gate_q <= 1'b0;
    end else if (restart) begin
      samp_q <= 1'b0;
      gate_q <= 1'b0;
    end else if (tap_fall) begin
      samp_q <= ~samp_q;
      if (samp_q) gate_q <= ~gate_q;
    end
  end

  assign win_open  = samp_q & gate_q;
  assign clr_pulse = tap_fall & samp_q & ~gate_q;
  assign win_close = tap_fall & samp_q & gate_q;
endmodule

// File: rtl/fgm_bcd_counter.sv
module fgm_bcd_counter
  import fgm_pkg::*;
#(
  parameter int DIGITS = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                inc,
  output logic [NIB*DIGITS-1:0] count,
  output logic                ovf
);
  logic [DIGITS-1:0] nine;
  logic [DIGITS-1:0] up;
  logic              full;

  assign full  = &nine;
  assign up[0] = inc & ~full;

  for (genvar k = 0; k < DIGITS; k++) begin : g_dig
    bcd_digit_t d;
    assign nine[k] = (d == BCD_TOP);
    if (k < DIGITS - 1) begin : g_chain
      assign up[k+1] = up[k] & nine[k];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     d <= '0;
      else if (clr)   d <= '0;
      else if (up[k]) d <= nine[k] ? '0 : d + 1'b1;
    end
    assign count[NIB*k +: NIB] = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           ovf <= 1'b0;
    else if (clr)         ovf <= 1'b0;
    else if (inc && full) ovf <= 1'b1;
  end
endmodule

// File: rtl/freq_gate_meter.sv
module freq_gate_meter #(
  parameter int STAGES = 5,
  parameter int RADIX  = 10,
  parameter int DIGITS = 5,
  localparam int SW    = (STAGES > 1) ? $clog2(STAGES) : 1,
  localparam int RW    = 4 * DIGITS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_tick,
  input  logic          sig_in,
  input  logic [SW-1:0] range_sel,
  output logic [RW-1:0] result,
  output logic          overflow,
  output logic          done
);
  logic [SW-1:0]     sel_eff, range_q;
  logic              restart;
  logic [STAGES-1:0] carry;
  logic              rise, win_open, clr_pulse, win_close;
  logic [RW-1:0]     cnt;
  logic              cnt_ovf;
  logic              close_d;

  always_comb begin
    if (int'(range_sel) > STAGES - 1) sel_eff = SW'(STAGES - 1);
    else                              sel_eff = range_sel;
  end
  assign restart = (sel_eff != range_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) range_q <= '0;
    else        range_q <= sel_eff;
  end

  fgm_timebase #(.STAGES(STAGES), .RADIX(RADIX)) u_tb (
    .clk(clk), .rst_n(rst_n), .restart(restart), .tick(ref_tick), .carry(carry)
  );

  fgm_edge_sync u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(sig_in), .rise(rise)
  );

  fgm_gate_ctrl #(.STAGES(STAGES), .SW(SW)) u_gate (
    .clk(clk), .rst_n(rst_n), .restart(restart), .carry(carry), .sel(range_q),
    .win_open(win_open), .clr_pulse(clr_pulse), .win_close(win_close)
  );

  fgm_bcd_counter #(.DIGITS(DIGITS)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(clr_pulse | restart), .inc(rise & win_open),
    .count(cnt), .ovf(cnt_ovf)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      close_d  <= 1'b0;
      done     <= 1'b0;
      result   <= '0;
      overflow <= 1'b0;
    end else begin
      close_d <= win_close & ~restart;
      done    <= close_d;
      if (close_d) begin
        result   <= cnt;
        overflow <= cnt_ovf;
      end
    end
  end
endmodule

// File: rtl/fgm_checker.sv
module fgm_checker #(
  parameter int DIGITS = 5,
  parameter int SW     = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [SW-1:0]     range_sel,
  input logic [4*DIGITS-1:0] result,
  input logic              overflow,
  input logic              done
);
  localparam logic [4*DIGITS-1:0] NINES = {DIGITS{4'd9}};

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(result) && $stable(overflow)));

  // R7
  sat_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> (result == NINES));

  // R9
  restart_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (range_sel != $past(range_sel)) |=> ##1 !done);

  // R5
  always @(posedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < DIGITS; i++) begin
        bcd_digit_chk: assert (result[4*i +: 4] <= 4'd9)
          else $error("digit %0d out of range", i);
      end
    end
  end
endmodule

bind freq_gate_meter fgm_checker #(.DIGITS(DIGITS), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .range_sel(range_sel),
  .result(result), .overflow(overflow), .done(done)
);

// File: tb/sim_freq_gate_meter.sv
`timescale 1ns/1ps
module sim_freq_gate_meter;
  localparam int TD = 3;          // digits of the bench instance
  localparam int MAXV = 999;

  logic clk = 1'b0, rst_n = 1'b0, ref_tick = 1'b0, sig_in = 1'b0;
  logic [2:0] range_sel = 3'd0;
  logic [4*TD-1:0] result;
  logic overflow, done;

  always #4 clk = ~clk;

  freq_gate_meter #(.DIGITS(TD)) u0 (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .sig_in(sig_in),
    .range_sel(range_sel), .result(result), .overflow(overflow), .done(done)
  );

  int n_run = 0, n_fail = 0, cyc = 0;
  int tick_every = 0, tcnt = 0, sig_half = 0, scnt = 0;
  logic sig_level = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  // stimulus generators, driven away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (tick_every > 0) begin
      ref_tick = (tcnt == 0);
      tcnt = (tcnt + 1) % tick_every;
    end else ref_tick = 1'b0;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (sig_half > 0) begin
      scnt++;
      if (scnt >= sig_half) begin scnt = 0; sig_in = ~sig_in; end
    end else if (sig_half < 0) sig_in = lfsr[0];
    else sig_in = sig_level;
  end

  // behavioural reference model
  int m_ref, m_phase, m_cnt, m_rq;
  bit m_ovf, m_close, m_done, m_rov;
  int m_res;
  bit h1, h2, h3;

  function automatic logic [4*TD-1:0] to_bcd(input int v);
    logic [4*TD-1:0] r = '0;
    int x = v;
    for (int i = 0; i < TD; i++) begin r[4*i +: 4] = 4'(x % 10); x = x / 10; end
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ref = 0; m_phase = 0; m_cnt = 0; m_rq = 0; m_ovf = 0; m_close = 0;
      m_done = 0; m_res = 0; m_rov = 0; h1 = 0; h2 = 0; h3 = 0;
    end else begin
      int sel, per;
      bit restart, fall, edge_seen, open, closing, clr;
      sel = (int'(range_sel) > 4) ? 4 : int'(range_sel);
      restart = (sel != m_rq);
      per = 10 ** (m_rq + 1);
      fall = ref_tick && ((m_ref % per) == per - 1);
      edge_seen = h2 && !h3;
      open = (m_phase == 3);
      closing = fall && open;
      clr = fall && (m_phase == 1);
      m_done = m_close;
      if (m_close) begin m_res = m_cnt; m_rov = m_ovf; end
      if (restart || clr) begin m_cnt = 0; m_ovf = 0; end
      else if (open && edge_seen) begin
        if (m_cnt == MAXV) m_ovf = 1; else m_cnt++;
      end
      m_close = closing && !restart;
      if (restart) begin m_ref = 0; m_phase = 0; m_rq = sel; end
      else if (ref_tick) begin
        if (fall) m_phase = (m_phase + 1) % 4;
        m_ref = (m_ref + 1) % 100000;
      end
      h3 = h2; h2 = h1; h1 = sig_in;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      check(result == to_bcd(m_res), "R5 result vs model", int'(result), int'(to_bcd(m_res)));
      check(overflow == m_rov, "R7 overflow vs model", int'(overflow), int'(m_rov));
      check(done == m_done, "R6 done vs model", int'(done), int'(m_done));
    end
  end

  int last_done;
  task automatic wait_done(input int limit, output bit seen);
    seen = 0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (done) begin seen = 1; last_done = cyc; return; end
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (190000) @(negedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, 190000);
    finish_run();
  end

  initial begin
    bit seen;
    int t1, dcount;
    repeat (5) @(negedge clk);
    // R1 reset state
    check(result == '0 && !overflow && !done, "R1 reset outputs", int'(result), 0);
    rst_n = 1'b1;
    tick_every = 1; sig_half = 2;
    repeat (3) @(negedge clk);
    check(result == '0 && !done, "R1 idle after reset", int'(result), 0);

    // R2: 10-tick window, input period 4 -> 2 or 3 edges
    wait_done(200, seen);
    check(seen, "R2 first done seen", int'(seen), 1);
    check(result == 12'h002 || result == 12'h003, "R2 short window count", int'(result), 2);
    t1 = last_done;
    wait_done(200, seen);
    // R3 spacing of four tap periods
    check(last_done - t1 == 40, "R3 done spacing sel0", last_done - t1, 40);

    // R4: steady high level counts nothing
    sig_half = 0; sig_level = 1'b1;
    wait_done(200, seen);
    wait_done(200, seen);
    check(seen && result == 12'h000, "R4 steady level", int'(result), 0);

    // R3 with slower tick and random input
    range_sel = 3'd1; tick_every = 2; sig_half = -1;
    wait_done(2000, seen);
    t1 = last_done;
    wait_done(2000, seen);
    check(seen && (last_done - t1 == 800), "R3 done spacing sel1", last_done - t1, 800);

    // R9: range change mid-measurement
    repeat (500) @(negedge clk);
    range_sel = 3'd0; tick_every = 1; sig_half = 2;
    dcount = 0;
    for (int i = 0; i < 30; i++) begin @(negedge clk); if (done) dcount++; end
    check(dcount == 0, "R9 no stale done", dcount, 0);
    wait_done(60, seen);
    check(seen, "R9 fresh done after restart", int'(seen), 1);

    // R10: no ticks, no progress
    tick_every = 0;
    dcount = 0;
    for (int i = 0; i < 400; i++) begin @(negedge clk); if (done) dcount++; end
    check(dcount == 0, "R10 frozen without ticks", dcount, 0);
    tick_every = 1;
    wait_done(80, seen);
    check(seen, "R10 resumes with ticks", int'(seen), 1);

    // R7: 10000-cycle window, edge every 2 cycles -> saturate
    range_sel = 3'd3; sig_half = 1;
    wait_done(45000, seen);
    check(seen && result == 12'h999, "R7 saturated value", int'(result), 'h999);
    check(overflow, "R7 overflow flag", int'(overflow), 1);

    // R8 / R5: 1000-cycle window, period 4 -> exactly 250
    range_sel = 3'd2; sig_half = 2;
    wait_done(4500, seen);
    check(seen && result == 12'h250, "R5 R8 exact BCD count", int'(result), 'h250);
    check(!overflow, "R8 overflow cleared", int'(overflow), 0);

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule